// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block accepts interrupt messages from two sources, a 64-bit interprocessor command register written as two 32-bit words and a message-signalled interrupt address/data pair, and turns each one into a set of target units plus an action on those units. The target set is formed from a destination shorthand, or from a physical or logical destination matched against the configuration of every unit. The action is either a vector strobe (fixed, lowest-priority and external modes), an SMI, NMI or INIT pulse, a startup pulse carrying a start vector, or an arbitration-ID resynchronisation pulse.

Each unit's physical ID, 8-bit logical ID and 4-bit destination format arrive as flattened configuration buses. A message is accepted with a valid/ready handshake, its outputs appear as one-cycle pulses in the following cycle with a busy flag raised, and a message offered during that cycle waits. Receiving controllers and any arbitration richer than picking the lowest index sit outside the block.

Top module: `irq_dispatch_hub`

## Requirements
- R1: With shorthand 0 and destination mode 0 (physical), destination 0xFF targets every unit; any other value targets only the lowest-index unit whose physical ID equals it, and no unit when none does.
- R2: With shorthand 0 and destination mode 1 (logical), a unit whose format is 0xF (flat) is targeted when the destination ANDed with its logical ID is nonzero.
- R3: In logical mode a unit whose format is 0x0 (cluster) is targeted when the upper nibbles of destination and logical ID are equal and their lower nibbles share a set bit; a unit with any other format is never targeted by logical matching.
- R4: A command low word carries vector [7:0], delivery mode [10:8], destination mode [11], level [14], trigger [15] and shorthand [19:18]; writing it sends a message whose destination is bits [31:24] of the last high word written, and a high-word write alone sends nothing.
- R5: Shorthand 1 targets only the sender unit, 2 targets every unit, 3 targets every unit except the sender.
- R6: Delivery modes 0 (fixed) and 7 (external) strobe every targeted unit on fixed_strobe with the vector on fixed_vector and the trigger bit on fixed_trigger.
- R7: Delivery mode 1 (lowest priority) strobes only the lowest-index targeted unit, and nothing when the target set is empty.
- R8: Delivery modes 2, 4 and 5 pulse smi_pulse, nmi_pulse and init_pulse respectively for every targeted unit; mode 3 produces no output at all.
- R9: A command with mode 5, level 0 and trigger 1 pulses arb_resync for the targeted units and nothing else.
- R10: Delivery mode 6 pulses start_pulse for every targeted unit with the vector on start_vector.
- R11: An MSI takes destination from address [19:12], destination mode from address [2], vector from data [7:0], delivery mode from data [10:8] and trigger from data [15], always uses shorthand 0, never applies the R9 rule, and ignores every other address and data bit.
- R12: Outputs of an accepted message last exactly the next cycle with busy high; both ready outputs are low while busy; when a command low word and an MSI are offered together the command goes first and the MSI waits.
- R13: After reset every output pulse and busy are low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_phys_id | input | NUM_UNITS*8 | Physical ID of each unit, unit i in bits [8i+7:8i] |
| unit_logic_id | input | NUM_UNITS*8 | Logical ID of each unit |
| unit_format | input | NUM_UNITS*4 | Destination format of each unit (0xF flat, 0x0 cluster) |
| cmd_valid | input | 1 | Command register write request |
| cmd_sel_hi | input | 1 | 1 selects the high word, 0 the low word (sends) |
| cmd_wdata | input | 32 | Command word data |
| cmd_sender | input | SRC_W | Index of the unit writing the command |
| cmd_ready | output | 1 | Command write accepted when high |
| msi_valid | input | 1 | MSI request |
| msi_addr | input | 32 | MSI address |
| msi_data | input | 32 | MSI data |
| msi_ready | output | 1 | MSI accepted when high |
| busy | output | 1 | High in the cycle carrying a message's outputs |
| fixed_strobe | output | NUM_UNITS | Vector delivery strobe per unit |
| fixed_vector | output | 8 | Vector for fixed_strobe |
| fixed_trigger | output | 1 | Trigger mode for fixed_strobe |
| smi_pulse | output | NUM_UNITS | SMI pulse per unit |
| nmi_pulse | output | NUM_UNITS | NMI pulse per unit |
| init_pulse | output | NUM_UNITS | INIT pulse per unit |
| start_pulse | output | NUM_UNITS | Startup pulse per unit |
| start_vector | output | 8 | Start vector for start_pulse |
| arb_resync | output | NUM_UNITS | Arbitration-ID resynchronisation pulse per unit |

## Verification
The hardest situation to reach is a command low word and an MSI offered in the same cycle, since it needs both sources to line up exactly on one edge; the bench raises both valids at the same falling edge and then follows the MSI through its stall and the busy cycle until it is taken. The duplicate-physical-ID case is set up by giving two units the same ID in the configuration, so only the lower one must respond, and a unit with an undefined format is included so that logical matching must skip it.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_ALL    = 8'hFF;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXTERN = 3'd7
  } dlv_mode_e;

  typedef struct packed {
    logic [7:0] vector;
    dlv_mode_e  mode;
    logic       logical;
    logic       level;
    logic       trigger;
    logic [1:0] shorthand;
    logic [7:0] dest;
    logic       from_cmd;
  } irq_msg_t;

  function automatic logic flat_hit(input logic [7:0] dest, input logic [7:0] lid);
    return |(dest & lid);
  endfunction

  function automatic logic cluster_hit(input logic [7:0] dest, input logic [7:0] lid);
    return (dest[7:4] == lid[7:4]) && (|(dest[3:0] & lid[3:0]));
  endfunction

  function automatic irq_msg_t cmd_to_msg(input logic [31:0] lo, input logic [7:0] dest);
    irq_msg_t m;
    m.vector    = lo[7:0];
    m.mode      = dlv_mode_e'(lo[10:8]);
    m.logical   = lo[11];
    m.level     = lo[14];
    m.trigger   = lo[15];
    m.shorthand = lo[19:18];
    m.dest      = dest;
    m.from_cmd  = 1'b1;
    return m;
  endfunction

  function automatic irq_msg_t msi_to_msg(input logic [31:0] addr, input logic [31:0] data);
    irq_msg_t m;
    m.vector    = data[7:0];
    m.mode      = dlv_mode_e'(data[10:8]);
    m.logical   = addr[2];
    m.level     = 1'b1;
    m.trigger   = data[15];
    m.shorthand = 2'd0;
    m.dest      = addr[19:12];
    m.from_cmd  = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/irq_msg_source.sv
module irq_msg_source
  import irq_hub_pkg::*;
#(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             cmd_valid,
  input  logic             cmd_sel_hi,
  input  logic [31:0]      cmd_wdata,
  input  logic [SRC_W-1:0] cmd_sender,
  output logic             cmd_ready,
  input  logic             msi_valid,
  input  logic [31:0]      msi_addr,
  input  logic [31:0]      msi_data,
  output logic             msi_ready,
  output logic             fire,
  output irq_msg_t         msg,
  output logic [SRC_W-1:0] sender
);

  logic [7:0] hi_dest_q;
  logic       cmd_take;
  logic       cmd_send;
  logic       msi_take;
  logic       cmd_lo_offer;

  assign cmd_lo_offer = cmd_valid && !cmd_sel_hi;
  assign cmd_ready    = !busy;
  assign msi_ready    = !busy && !cmd_lo_offer;
  assign cmd_take     = cmd_valid && cmd_ready;
  assign cmd_send     = cmd_take && !cmd_sel_hi;
  assign msi_take     = msi_valid && msi_ready;
  assign fire         = cmd_send || msi_take;
  assign sender       = cmd_sender;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_dest_q <= '0;
    end else if (cmd_take && cmd_sel_hi) begin
      hi_dest_q <= cmd_wdata[31:24];
    end
  end

  always_comb begin
    if (cmd_send) msg = cmd_to_msg(cmd_wdata, hi_dest_q);
    else          msg = msi_to_msg(msi_addr, msi_data);
  end

  p_no_fire_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fire);

  p_cmd_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_offer && msi_valid) |-> !msi_take);

endmodule

// File: rtl/irq_target_resolve.sv
module irq_target_resolve
  import irq_hub_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int SRC_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  irq_msg_t               msg,
  input  logic [SRC_W-1:0]       sender,
  input  logic [NUM_UNITS*8-1:0] phys_cfg,
  input  logic [NUM_UNITS*8-1:0] logic_cfg,
  input  logic [NUM_UNITS*4-1:0] fmt_cfg,
  output logic [NUM_UNITS-1:0]   mask
);

  localparam logic [NUM_UNITS-1:0] ONE = {{(NUM_UNITS-1){1'b0}}, 1'b1};

  logic [NUM_UNITS-1:0] phys_hit;
  logic [NUM_UNITS-1:0] phys_first;
  logic [NUM_UNITS-1:0] log_hit;
  logic [NUM_UNITS-1:0] self_mask;
  logic [NUM_UNITS-1:0] dest_mask;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    logic [7:0] pid;
    logic [7:0] lid;
    logic [3:0] fmt;
    assign pid = phys_cfg[i*8 +: 8];
    assign lid = logic_cfg[i*8 +: 8];
    assign fmt = fmt_cfg[i*4 +: 4];
    assign phys_hit[i] = (pid == msg.dest);
    always_comb begin
      if (fmt == FMT_FLAT)         log_hit[i] = flat_hit(msg.dest, lid);
      else if (fmt == FMT_CLUSTER) log_hit[i] = cluster_hit(msg.dest, lid);
      else                         log_hit[i] = 1'b0;
    end
  end

  assign phys_first = phys_hit & (~phys_hit + ONE);

  always_comb begin
    self_mask = '0;
    if (int'(sender) < NUM_UNITS) self_mask[sender] = 1'b1;
  end

  always_comb begin
    if (msg.logical)              dest_mask = log_hit;
    else if (msg.dest == DEST_ALL) dest_mask = '1;
    else                          dest_mask = phys_first;
  end

  always_comb begin
    unique case (msg.shorthand)
      2'd0:    mask = dest_mask;
      2'd1:    mask = self_mask;
      2'd2:    mask = '1;
      default: mask = ~self_mask;
    endcase
  end

  p_phys_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && msg.shorthand == 2'd0 && !msg.logical && msg.dest != DEST_ALL)
      |-> ($countones(mask) <= 1));

  p_self_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && msg.shorthand == 2'd1) |-> $onehot0(mask));

endmodule

// File: rtl/irq_action_dispatch.sv
module irq_action_dispatch
  import irq_hub_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  irq_msg_t             msg,
  input  logic [NUM_UNITS-1:0] mask,
  output logic                 busy,
  output logic [NUM_UNITS-1:0] fixed_strobe,
  output logic [7:0]           fixed_vector,
  output logic                 fixed_trigger,
  output logic [NUM_UNITS-1:0] smi_pulse,
  output logic [NUM_UNITS-1:0] nmi_pulse,
  output logic [NUM_UNITS-1:0] init_pulse,
  output logic [NUM_UNITS-1:0] start_pulse,
  output logic [7:0]           start_vector,
  output logic [NUM_UNITS-1:0] arb_resync
);

  localparam logic [NUM_UNITS-1:0] ONE = {{(NUM_UNITS-1){1'b0}}, 1'b1};

  logic [NUM_UNITS-1:0] lowest_pick;
  logic                 init_deassert;
  logic                 any_out;

  assign lowest_pick   = mask & (~mask + ONE);
  assign init_deassert = msg.from_cmd && !msg.level && msg.trigger;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      fixed_strobe  <= '0;
      fixed_vector  <= '0;
      fixed_trigger <= 1'b0;
      smi_pulse     <= '0;
      nmi_pulse     <= '0;
      init_pulse    <= '0;
      start_pulse   <= '0;
      start_vector  <= '0;
      arb_resync    <= '0;
    end else begin
      busy         <= fire;
      fixed_strobe <= '0;
      smi_pulse    <= '0;
      nmi_pulse    <= '0;
      init_pulse   <= '0;
      start_pulse  <= '0;
      arb_resync   <= '0;
      if (fire) begin
        unique case (msg.mode)
          DM_FIXED, DM_EXTERN: begin
            fixed_strobe  <= mask;
            fixed_vector  <= msg.vector;
            fixed_trigger <= msg.trigger;
          end
          DM_LOWEST: begin
            fixed_strobe  <= lowest_pick;
            fixed_vector  <= msg.vector;
            fixed_trigger <= msg.trigger;
          end
          DM_SMI: smi_pulse <= mask;
          DM_NMI: nmi_pulse <= mask;
          DM_INIT: begin
            if (init_deassert) arb_resync <= mask;
            else               init_pulse <= mask;
          end
          DM_START: begin
            start_pulse  <= mask;
            start_vector <= msg.vector;
          end
          default: ;
        endcase
      end
    end
  end

  assign any_out = |{fixed_strobe, smi_pulse, nmi_pulse, init_pulse, start_pulse, arb_resync};

  p_family_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|fixed_strobe, |smi_pulse, |nmi_pulse, |init_pulse, |start_pulse, |arb_resync}));

  p_lowest_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && msg.mode == DM_LOWEST && |mask) |=> $onehot(fixed_strobe));

  p_resync_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && msg.mode == DM_INIT && msg.from_cmd && !msg.level && msg.trigger)
      |=> (init_pulse == '0));

  p_rsvd_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && msg.mode == DM_RSVD) |=> !any_out);

  p_busy_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !any_out);

  p_fire_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> busy);

endmodule

// File: rtl/irq_dispatch_hub.sv
module irq_dispatch_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int SRC_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_UNITS*8-1:0] unit_phys_id,
  input  logic [NUM_UNITS*8-1:0] unit_logic_id,
  input  logic [NUM_UNITS*4-1:0] unit_format,
  input  logic                   cmd_valid,
  input  logic                   cmd_sel_hi,
  input  logic [31:0]            cmd_wdata,
  input  logic [SRC_W-1:0]       cmd_sender,
  output logic                   cmd_ready,
  input  logic                   msi_valid,
  input  logic [31:0]            msi_addr,
  input  logic [31:0]            msi_data,
  output logic                   msi_ready,
  output logic                   busy,
  output logic [NUM_UNITS-1:0]   fixed_strobe,
  output logic [7:0]             fixed_vector,
  output logic                   fixed_trigger,
  output logic [NUM_UNITS-1:0]   smi_pulse,
  output logic [NUM_UNITS-1:0]   nmi_pulse,
  output logic [NUM_UNITS-1:0]   init_pulse,
  output logic [NUM_UNITS-1:0]   start_pulse,
  output logic [7:0]             start_vector,
  output logic [NUM_UNITS-1:0]   arb_resync
);

  logic                 fire;
  irq_msg_t             msg;
  logic [SRC_W-1:0]     sender;
  logic [NUM_UNITS-1:0] target_mask;

  irq_msg_source #(.SRC_W(SRC_W)) u_source (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cmd_valid  (cmd_valid),
    .cmd_sel_hi (cmd_sel_hi),
    .cmd_wdata  (cmd_wdata),
    .cmd_sender (cmd_sender),
    .cmd_ready  (cmd_ready),
    .msi_valid  (msi_valid),
    .msi_addr   (msi_addr),
    .msi_data   (msi_data),
    .msi_ready  (msi_ready),
    .fire       (fire),
    .msg        (msg),
    .sender     (sender)
  );

  irq_target_resolve #(.NUM_UNITS(NUM_UNITS), .SRC_W(SRC_W)) u_resolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .msg       (msg),
    .sender    (sender),
    .phys_cfg  (unit_phys_id),
    .logic_cfg (unit_logic_id),
    .fmt_cfg   (unit_format),
    .mask      (target_mask)
  );

  irq_action_dispatch #(.NUM_UNITS(NUM_UNITS)) u_dispatch (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .msg           (msg),
    .mask          (target_mask),
    .busy          (busy),
    .fixed_strobe  (fixed_strobe),
    .fixed_vector  (fixed_vector),
    .fixed_trigger (fixed_trigger),
    .smi_pulse     (smi_pulse),
    .nmi_pulse     (nmi_pulse),
    .init_pulse    (init_pulse),
    .start_pulse   (start_pulse),
    .start_vector  (start_vector),
    .arb_resync    (arb_resync)
  );

  p_ready_low_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!cmd_ready && !msi_ready));

endmodule

// File: tb/irq_dispatch_hub_test.sv
module irq_dispatch_hub_test;

  localparam int N          = 8;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        is_msi;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [2:0]  snd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0040, 32'h1300_0000, 3'd0, 8'd1},   // R1 physical match unit3
    '{1'b0, 32'h0000_8041, 32'h1200_0000, 3'd0, 8'd1},   // R1 duplicate ID, lowest wins
    '{1'b0, 32'h0000_0042, 32'hFF00_0000, 3'd0, 8'd1},   // R1 broadcast
    '{1'b0, 32'h0000_0043, 32'h7700_0000, 3'd0, 8'd1},   // R1 no match
    '{1'b0, 32'h0000_0844, 32'h0500_0000, 3'd0, 8'd2},   // R2 flat
    '{1'b0, 32'h0000_0845, 32'h3300_0000, 3'd0, 8'd3},   // R3 cluster + flat mix
    '{1'b0, 32'h0004_0200, 32'h3300_0000, 3'd6, 8'd5},   // R5 self, SMI
    '{1'b0, 32'h0008_0400, 32'h3300_0000, 3'd1, 8'd5},   // R5 all, NMI
    '{1'b0, 32'h000C_0046, 32'h3300_0000, 3'd2, 8'd5},   // R5 all but self
    '{1'b0, 32'h0000_0946, 32'h0C00_0000, 3'd0, 8'd7},   // R7 lowest of logical set
    '{1'b0, 32'h000C_0147, 32'h0C00_0000, 3'd0, 8'd7},   // R7 lowest excluding sender0
    '{1'b0, 32'h0000_4500, 32'h1100_0000, 3'd0, 8'd8},   // R8 INIT assert
    '{1'b0, 32'h0008_8500, 32'h1100_0000, 3'd4, 8'd9},   // R9 INIT deassert resync
    '{1'b0, 32'h0008_0300, 32'h1100_0000, 3'd0, 8'd8},   // R8 mode 3 ignored
    '{1'b0, 32'h0000_069A, 32'hFF00_0000, 3'd0, 8'd10},  // R10 startup
    '{1'b0, 32'h0008_8730, 32'hFF00_0000, 3'd0, 8'd6},   // R6 external
    '{1'b1, 32'hFEE1_4000, 32'h0000_8052, 3'd0, 8'd11},  // R11 MSI physical
    '{1'b1, 32'hFEE3_300C, 32'h0000_0155, 3'd0, 8'd11},  // R11 MSI logical lowest, hint set
    '{1'b1, 32'hFEEF_F000, 32'h0000_8500, 3'd0, 8'd11},  // R11 MSI INIT never resyncs
    '{1'b1, 32'hFEE1_6000, 32'hABCD_4060, 3'd0, 8'd11}   // R11 junk data bits ignored
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*8-1:0] unit_phys_id, unit_logic_id;
  logic [N*4-1:0] unit_format;
  logic cmd_valid = 1'b0, cmd_sel_hi = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [2:0] cmd_sender = '0;
  logic cmd_ready;
  logic msi_valid = 1'b0;
  logic [31:0] msi_addr = '0, msi_data = '0;
  logic msi_ready, busy, fixed_trigger;
  logic [N-1:0] fixed_strobe, smi_pulse, nmi_pulse, init_pulse, start_pulse, arb_resync;
  logic [7:0] fixed_vector, start_vector;

  logic [7:0] b_phys [N];
  logic [7:0] b_log  [N];
  logic [3:0] b_fmt  [N];

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      unit_phys_id[i*8 +: 8]  = b_phys[i];
      unit_logic_id[i*8 +: 8] = b_log[i];
      unit_format[i*4 +: 4]   = b_fmt[i];
    end
  end

  irq_dispatch_hub #(.NUM_UNITS(N)) uut (
    .clk(clk), .rst_n(rst_n),
    .unit_phys_id(unit_phys_id), .unit_logic_id(unit_logic_id), .unit_format(unit_format),
    .cmd_valid(cmd_valid), .cmd_sel_hi(cmd_sel_hi), .cmd_wdata(cmd_wdata),
    .cmd_sender(cmd_sender), .cmd_ready(cmd_ready),
    .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data), .msi_ready(msi_ready),
    .busy(busy), .fixed_strobe(fixed_strobe), .fixed_vector(fixed_vector),
    .fixed_trigger(fixed_trigger), .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse),
    .init_pulse(init_pulse), .start_pulse(start_pulse), .start_vector(start_vector),
    .arb_resync(arb_resync)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Target set computed from the requirement text (R1, R2, R3, R5).
  function automatic logic [N-1:0] model_mask(input logic [7:0] dest, input logic dm,
                                              input logic [1:0] sh, input int snd);
    logic [N-1:0] m;
    m = '0;
    if (sh == 2'd1) m[snd] = 1'b1;
    else if (sh == 2'd2) m = '1;
    else if (sh == 2'd3) begin m = '1; m[snd] = 1'b0; end
    else if (!dm) begin
      if (dest == 8'hFF) m = '1;
      else for (int i = N-1; i >= 0; i--) if (b_phys[i] == dest) begin m = '0; m[i] = 1'b1; end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (b_fmt[i] == 4'hF) m[i] = ((dest & b_log[i]) != 8'h00);
        else if (b_fmt[i] == 4'h0)
          m[i] = (dest[7:4] == b_log[i][7:4]) && ((dest[3:0] & b_log[i][3:0]) != 4'h0);
      end
    end
    return m;
  endfunction

  task automatic run_vec(input vec_t v);
    logic [7:0] dest, vec;
    logic dm, lvl, trg;
    logic [1:0] sh;
    logic [2:0] mode;
    logic [N-1:0] m, e_fix, e_smi, e_nmi, e_init, e_start, e_arb;
    string tag;
    tag = $sformatf("R%0d", v.req);
    if (v.is_msi) begin
      dest = v.w0[19:12]; dm = v.w0[2]; sh = 2'd0;
      vec = v.w1[7:0]; mode = v.w1[10:8]; trg = v.w1[15]; lvl = 1'b1;
    end else begin
      dest = v.w1[31:24]; dm = v.w0[11]; sh = v.w0[19:18];
      vec = v.w0[7:0]; mode = v.w0[10:8]; trg = v.w0[15]; lvl = v.w0[14];
    end
    m = model_mask(dest, dm, sh, int'(v.snd));
    e_fix = '0; e_smi = '0; e_nmi = '0; e_init = '0; e_start = '0; e_arb = '0;
    case (mode)
      3'd0, 3'd7: e_fix = m;
      3'd1: for (int i = N-1; i >= 0; i--) if (m[i]) begin e_fix = '0; e_fix[i] = 1'b1; end
      3'd2: e_smi = m;
      3'd4: e_nmi = m;
      3'd5: if (!v.is_msi && !lvl && trg) e_arb = m; else e_init = m;
      3'd6: e_start = m;
      default: ;
    endcase
    @(negedge clk);
    if (v.is_msi) begin
      msi_valid = 1'b1; msi_addr = v.w0; msi_data = v.w1;
    end else begin
      cmd_valid = 1'b1; cmd_sel_hi = 1'b1; cmd_wdata = v.w1;
      @(negedge clk);
      cmd_sel_hi = 1'b0; cmd_wdata = v.w0; cmd_sender = v.snd;
    end
    @(negedge clk);
    cmd_valid = 1'b0; msi_valid = 1'b0;
    check({fixed_strobe, smi_pulse, nmi_pulse, init_pulse, start_pulse, arb_resync, busy} ==
          {e_fix, e_smi, e_nmi, e_init, e_start, e_arb, 1'b1}, tag,
          {15'd0, fixed_strobe, smi_pulse, nmi_pulse, init_pulse, start_pulse, arb_resync, busy},
          {15'd0, e_fix, e_smi, e_nmi, e_init, e_start, e_arb, 1'b1});
    if (e_fix != '0)
      check({fixed_vector, fixed_trigger} == {vec, trg}, tag,
            64'({fixed_vector, fixed_trigger}), 64'({vec, trg}));
    if (e_start != '0)
      check(start_vector == vec, tag, 64'(start_vector), 64'(vec));
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      b_phys[i] = 8'h10 + 8'(i);
      b_fmt[i]  = 4'hF;
      b_log[i]  = 8'h01 << i;
    end
    b_phys[5] = 8'h12;                       // duplicate of unit2
    b_fmt[4] = 4'h0; b_log[4] = 8'h31;
    b_fmt[5] = 4'h0; b_log[5] = 8'h32;
    b_fmt[6] = 4'h0; b_log[6] = 8'h43;
    b_fmt[7] = 4'h5; b_log[7] = 8'hFF;       // undefined format, R3

    repeat (3) @(negedge clk);
    // R13 reset state
    check({fixed_strobe, smi_pulse, nmi_pulse, init_pulse, start_pulse, arb_resync, busy,
           cmd_ready, msi_ready} == {(6*N+1)'(0), 2'b11}, "R13",
          64'({fixed_strobe, smi_pulse, nmi_pulse, init_pulse, start_pulse, arb_resync, busy,
               cmd_ready, msi_ready}), 64'd3);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, fixed_strobe} == '0, "R13", 64'({busy, fixed_strobe}), 64'd0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R4: a high word alone sends nothing; a later low word reuses it
    cmd_valid = 1'b1; cmd_sel_hi = 1'b1; cmd_wdata = 32'h1300_0000;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({busy, fixed_strobe} == '0, "R4", 64'({busy, fixed_strobe}), 64'd0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel_hi = 1'b0; cmd_wdata = 32'h0000_0050;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({fixed_strobe, fixed_vector} == {8'b0000_1000, 8'h50}, "R4",
          64'({fixed_strobe, fixed_vector}), 64'h0850);
    @(negedge clk);

    // R12: simultaneous command and MSI
    cmd_valid = 1'b1; cmd_sel_hi = 1'b0; cmd_wdata = 32'h0008_0021;
    msi_valid = 1'b1; msi_addr = 32'hFEE1_0000; msi_data = 32'h0000_0022;
    #1;
    check(msi_ready == 1'b0 && cmd_ready == 1'b1, "R12", 64'({msi_ready, cmd_ready}), 64'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check({busy, msi_ready, cmd_ready, fixed_strobe, fixed_vector} == {3'b100, 8'hFF, 8'h21}, "R12",
          64'({busy, msi_ready, cmd_ready, fixed_strobe, fixed_vector}), 64'({3'b100, 8'hFF, 8'h21}));
    @(negedge clk);
    check({busy, msi_ready, fixed_strobe} == {2'b01, 8'h00}, "R12",
          64'({busy, msi_ready, fixed_strobe}), 64'({2'b01, 8'h00}));
    @(negedge clk);
    msi_valid = 1'b0;
    check({busy, fixed_strobe, fixed_vector} == {1'b1, 8'h01, 8'h22}, "R12",
          64'({busy, fixed_strobe, fixed_vector}), 64'({1'b1, 8'h01, 8'h22}));
    @(negedge clk);
    check({busy, fixed_strobe} == '0, "R12", 64'({busy, fixed_strobe}), 64'd0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule